// File: doc/BRIEF.md
# Serial Downlink Control CRC-24 Generator and Checker

This block protects a downlink control payload with 24 parity bits, working one bit per clock. A frame opens with a start strobe, carries its payload bits on `bit_vld` cycles and closes with an end strobe. In generate mode the block then shifts out the 24 parity bits, highest-degree remainder term first. The register is preloaded so that the payload behaves as if 24 one-bits had been fed in ahead of it. A 16-bit receiver identity is merged by XOR onto the trailing 16 parity bits. A parity word made this way checks clean only at the receiver that knows the same identity.

In check mode the frame carries the payload followed by the 24 received parity bits. The block keeps the most recent 24 bits in a delay window, so only payload bits reach the remainder register. On the end strobe it removes the identity from the held parity and compares it with the computed remainder. A single-cycle result reports pass or fail. Frames with an empty or oversized payload are rejected with an error pulse.

Top module: `ctl_crc24_unit`

## Requirements
- R1: With identity zero, the 24 generated parity bits equal the remainder of (24 one-bits, then the payload, then 24 zero-bits) divided by D^24+D^23+D^21+D^20+D^17+D^15+D^13+D^12+D^8+D^4+D^2+D+1.
- R2: The first parity bit appears on `par_bit` with `par_vld` high in the cycle after the cycle that presented `frm_end`. `par_vld` stays high for exactly 24 consecutive cycles, highest-degree term first, and `busy` is low in the cycle after the last parity bit.
- R3: `ident` is captured on the accepted `frm_start`. Parity bits 1 to 8 (in emission order) are unchanged. Bit 9 is XORed with `ident[15]`, and so on down, until bit 24 is XORed with `ident[0]`.
- R4: In check mode, `res_vld` pulses for one cycle, in the cycle after `frm_end`. `res_pass` is 1 when the last 24 bits of the frame equal the parity that generate mode would emit for the preceding bits and the captured identity. It is never high without `res_vld`.
- R5: In check mode, a corrupted payload bit, a corrupted parity bit or a different identity gives `res_vld`=1, `res_pass`=0, `res_err`=0.
- R6: A generate frame with no payload bits gives `res_vld`=1 and `res_err`=1 in the cycle after `frm_end`, and no parity bits are emitted.
- R7: A payload of up to MAX_PAYLOAD (140) bits is accepted in either mode. A payload of 141 or more bits gives the error pulse of R6 instead of parity or a check result.
- R8: A `frm_start` in the cycle right after the last parity bit opens a new frame. A `frm_start` while `busy` is high is ignored.
- R9: During reset, `par_vld`, `busy`, `res_vld`, `res_pass` and `res_err` are 0.
- R10: A check frame of 24 or fewer bits (no payload) gives the error pulse of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| chk_mode | input | 1 | Mode captured with frm_start: 0 generate, 1 check |
| ident | input | 16 | Receiver identity captured with frm_start |
| frm_start | input | 1 | Opens a frame when idle |
| frm_end | input | 1 | Closes the open frame; a data bit on the same cycle is not taken |
| bit_vld | input | 1 | A frame bit is present on bit_dat |
| bit_dat | input | 1 | Frame bit |
| par_vld | output | 1 | A parity bit is on par_bit |
| par_bit | output | 1 | Parity bit, identity merged |
| busy | output | 1 | A frame is open or parity is being emitted |
| res_vld | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Check passed (valid with res_vld) |
| res_err | output | 1 | Frame length rejected (valid with res_vld) |

## Verification
The bench builds the block with its default parameters: a 24-bit parity, a 16-bit identity and a 140-bit payload limit. With these values the full-length case can be tested: a 140-bit payload, the 164-bit check frame it produces, and the 141-bit rejection. The reference is a long polynomial division over the bit queue with the 24 leading ones written out literally. It therefore tests the register preload as a separate claim, not as a copy of it.

// File: rtl/crc24u_pkg.sv
package crc24u_pkg;

  // Generator taps below the implicit leading term D^24.
  localparam logic [23:0] CRC24U_POLY_DEF = 24'hB2B117;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_EMIT = 2'd2
  } ctl_state_e;

endpackage

// File: rtl/crc_serial_core.sv
module crc_serial_core #(
  parameter int unsigned     W    = 24,
  parameter logic [W-1:0]    POLY = 24'hB2B117
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] state
);

  // One step of the shift-and-reduce division (remainder of M(x)*x^W).
  function automatic logic [W-1:0] adv(input logic [W-1:0] s, input logic b);
    logic [W-1:0] r;
    r = {s[W-2:0], 1'b0};
    if (b ^ s[W-1]) r = r ^ POLY;
    return r;
  endfunction

  // State reached after W leading one-bits from an empty register.
  function automatic logic [W-1:0] seed_fn();
    logic [W-1:0] s;
    s = '0;
    for (int i = 0; i < int'(W); i++) s = adv(s, 1'b1);
    return s;
  endfunction

  localparam logic [W-1:0] SEED = seed_fn();

  logic [W-1:0] rem_q;
  logic [W-1:0] rem_step;
  logic [W-1:0] rem_d;
  logic         fb;

  assign fb = din ^ rem_q[W-1];

  for (genvar i = 0; i < int'(W); i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign rem_step[i] = POLY[i] & fb;
    end else begin : g_up
      assign rem_step[i] = rem_q[i-1] ^ (POLY[i] & fb);
    end
  end

  always_comb begin
    rem_d = rem_q;
    if (load)      rem_d = SEED;
    else if (step) rem_d = rem_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign state = rem_q;

endmodule

// File: rtl/crc_rx_window.sv
module crc_rx_window #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] win
);

  logic [W-1:0] win_q;
  logic [W-1:0] win_d;

  always_comb begin
    win_d = win_q;
    if (clr)        win_d = '0;
    else if (shift) win_d = {win_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign win = win_q;

endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc24u_pkg::*;
#(
  parameter int unsigned W    = 24,
  parameter int unsigned ID_W = 16,
  parameter int unsigned MAXP = 140
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_mode,
  input  logic [ID_W-1:0] ident,
  input  logic            frm_start,
  input  logic            frm_end,
  input  logic            bit_vld,
  input  logic [W-1:0]    crc_state,
  input  logic [W-1:0]    win_state,
  output logic            core_load,
  output logic            core_step,
  output logic            core_sel_win,
  output logic            win_clr,
  output logic            win_shift,
  output logic            par_vld,
  output logic            par_bit,
  output logic            busy,
  output logic            res_vld,
  output logic            res_pass,
  output logic            res_err
);

  localparam int unsigned CNT_TOP = MAXP + W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_TOP + 1);
  localparam int unsigned IDX_W   = $clog2(W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_TOP);
  localparam logic [CNT_W-1:0] LEN_PAR  = CNT_W'(W);
  localparam logic [CNT_W-1:0] LEN_GMAX = CNT_W'(MAXP);
  localparam logic [CNT_W-1:0] LEN_CMAX = CNT_W'(MAXP + W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W - 1);

  ctl_state_e       state_q, state_d;
  logic             mode_q, mode_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [W-1:0]     sr_q, sr_d;
  logic             rv_q, rv_d;
  logic             rp_q, rp_d;
  logic             re_q, re_d;

  logic         accept_start;
  logic         bit_take;
  logic         cnt_full;
  logic         len_bad;
  logic [W-1:0] id_ext;
  logic         match;

  assign accept_start = (state_q == ST_IDLE) && frm_start;
  assign bit_take     = (state_q == ST_RECV) && bit_vld && !frm_end;
  assign cnt_full     = (cnt_q >= LEN_PAR);
  assign len_bad      = mode_q ? ((cnt_q <= LEN_PAR) || (cnt_q > LEN_CMAX))
                               : ((cnt_q == '0) || (cnt_q > LEN_GMAX));
  assign id_ext       = {{(W-ID_W){1'b0}}, id_q};
  assign match        = ((crc_state ^ id_ext) == win_state);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    id_d    = id_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sr_d    = sr_q;
    rv_d    = 1'b0;
    rp_d    = 1'b0;
    re_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frm_start) begin
          state_d = ST_RECV;
          mode_d  = chk_mode;
          id_d    = ident;
          cnt_d   = '0;
        end
      end
      ST_RECV: begin
        if (frm_end) begin
          if (len_bad) begin
            rv_d    = 1'b1;
            re_d    = 1'b1;
            state_d = ST_IDLE;
          end else if (mode_q) begin
            rv_d    = 1'b1;
            rp_d    = match;
            state_d = ST_IDLE;
          end else begin
            sr_d    = crc_state ^ id_ext;
            idx_d   = '0;
            state_d = ST_EMIT;
          end
        end else if (bit_vld && (cnt_q != CNT_SAT)) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_EMIT: begin
        sr_d  = {sr_q[W-2:0], 1'b0};
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_LAST) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      id_q    <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      sr_q    <= '0;
      rv_q    <= 1'b0;
      rp_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      id_q    <= id_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sr_q    <= sr_d;
      rv_q    <= rv_d;
      rp_q    <= rp_d;
      re_q    <= re_d;
    end
  end

  assign core_load    = accept_start;
  assign core_step    = bit_take && (!mode_q || cnt_full);
  assign core_sel_win = mode_q;
  assign win_clr      = accept_start;
  assign win_shift    = bit_take && mode_q;

  assign par_vld  = (state_q == ST_EMIT);
  assign par_bit  = sr_q[W-1];
  assign busy     = (state_q != ST_IDLE);
  assign res_vld  = rv_q;
  assign res_pass = rp_q;
  assign res_err  = re_q;

endmodule

// File: rtl/ctl_crc24_unit.sv
module ctl_crc24_unit
  import crc24u_pkg::*;
#(
  parameter int unsigned         CRC_W       = 24,
  parameter int unsigned         ID_W        = 16,
  parameter int unsigned         MAX_PAYLOAD = 140,
  parameter logic [CRC_W-1:0]    CRC_POLY    = CRC24U_POLY_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_mode,
  input  logic [ID_W-1:0] ident,
  input  logic            frm_start,
  input  logic            frm_end,
  input  logic            bit_vld,
  input  logic            bit_dat,
  output logic            par_vld,
  output logic            par_bit,
  output logic            busy,
  output logic            res_vld,
  output logic            res_pass,
  output logic            res_err
);

  logic [CRC_W-1:0] crc_state;
  logic [CRC_W-1:0] win_state;
  logic             core_load;
  logic             core_step;
  logic             core_sel_win;
  logic             win_clr;
  logic             win_shift;
  logic             core_din;

  // Check mode feeds the remainder only with bits that have left the window.
  assign core_din = core_sel_win ? win_state[CRC_W-1] : bit_dat;

  crc_serial_core #(
    .W    (CRC_W),
    .POLY (CRC_POLY)
  ) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (core_load),
    .step  (core_step),
    .din   (core_din),
    .state (crc_state)
  );

  crc_rx_window #(
    .W (CRC_W)
  ) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (win_clr),
    .shift (win_shift),
    .din   (bit_dat),
    .win   (win_state)
  );

  crc_frame_ctrl #(
    .W    (CRC_W),
    .ID_W (ID_W),
    .MAXP (MAX_PAYLOAD)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_mode     (chk_mode),
    .ident        (ident),
    .frm_start    (frm_start),
    .frm_end      (frm_end),
    .bit_vld      (bit_vld),
    .crc_state    (crc_state),
    .win_state    (win_state),
    .core_load    (core_load),
    .core_step    (core_step),
    .core_sel_win (core_sel_win),
    .win_clr      (win_clr),
    .win_shift    (win_shift),
    .par_vld      (par_vld),
    .par_bit      (par_bit),
    .busy         (busy),
    .res_vld      (res_vld),
    .res_pass     (res_pass),
    .res_err      (res_err)
  );

endmodule

// File: rtl/crc24u_chk.sv
module crc24u_chk #(
  parameter int unsigned W = 24
) (
  input logic clk,
  input logic rst_n,
  input logic frm_end,
  input logic par_vld,
  input logic busy,
  input logic res_vld,
  input logic res_pass,
  input logic res_err
);

  localparam int unsigned RUN_W = $clog2(W + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (par_vld) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  // R2
  par_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(par_vld) |-> (run_q == RUN_W'(W)));

  // R2
  par_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_vld) |-> $past(frm_end));

  // R8
  par_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_vld |-> busy);

  // R4
  res_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> ($past(frm_end) && $past(busy)));

  // R4
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);

  // R4
  pass_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_pass |-> res_vld);

  // R6
  err_no_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (res_vld && !res_pass));

  // R6
  err_no_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |=> !par_vld);

endmodule

bind ctl_crc24_unit crc24u_chk #(.W(CRC_W)) u_crc24u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frm_end  (frm_end),
  .par_vld  (par_vld),
  .busy     (busy),
  .res_vld  (res_vld),
  .res_pass (res_pass),
  .res_err  (res_err)
);

// File: tb/ctl_crc24_unit_bench.sv
module ctl_crc24_unit_bench;

  localparam int CW   = 24;
  localparam int IW   = 16;
  localparam int MAXP = 140;

  typedef bit bq_t[$];

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chk_mode;
  logic [IW-1:0] ident;
  logic          frm_start;
  logic          frm_end;
  logic          bit_vld;
  logic          bit_dat;
  logic          par_vld;
  logic          par_bit;
  logic          busy;
  logic          res_vld;
  logic          res_pass;
  logic          res_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ctl_crc24_unit u_ctl_crc24_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_mode  (chk_mode),
    .ident     (ident),
    .frm_start (frm_start),
    .frm_end   (frm_end),
    .bit_vld   (bit_vld),
    .bit_dat   (bit_dat),
    .par_vld   (par_vld),
    .par_bit   (par_bit),
    .busy      (busy),
    .res_vld   (res_vld),
    .res_pass  (res_pass),
    .res_err   (res_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Long division with the leading ones written out; returns parity,
  // first emitted bit in position 23, identity merged.
  function automatic logic [CW-1:0] ref_par(input bq_t q, input logic [IW-1:0] id);
    bit a[$];
    logic [24:0] g;
    logic [CW-1:0] r;
    g = 25'h1B2B117;
    for (int i = 0; i < CW; i++) a.push_back(1'b1);
    foreach (q[i]) a.push_back(q[i]);
    for (int i = 0; i < CW; i++) a.push_back(1'b0);
    for (int i = 0; i + 25 <= a.size(); i++) begin
      if (a[i]) for (int j = 0; j < 25; j++) a[i+j] = a[i+j] ^ g[24-j];
    end
    for (int k = 0; k < CW; k++) begin
      r[CW-1-k] = a[a.size()-CW+k];
      if (k >= 8) r[CW-1-k] = r[CW-1-k] ^ id[23-k];
    end
    return r;
  endfunction

  function automatic bq_t mk(input int n, input int s);
    bq_t q;
    for (int i = 0; i < n; i++) begin
      int v;
      v = i * 29 + s * 17 + ((i * i) >> 2);
      q.push_back(v[3] ^ v[0]);
    end
    return q;
  endfunction

  // Entered and left at a falling edge.
  task automatic send_frame(input bit m, input logic [IW-1:0] id, input bq_t q);
    frm_start = 1'b1; chk_mode = m; ident = id;
    @(negedge clk);
    frm_start = 1'b0;
    foreach (q[i]) begin
      bit_vld = 1'b1; bit_dat = q[i];
      @(negedge clk);
    end
    bit_vld = 1'b0; frm_end = 1'b1;
    @(negedge clk);
    frm_end = 1'b0;
  endtask

  task automatic gen_run(input logic [IW-1:0] id, input bq_t q, input string req,
                         input bit poke);
    logic [CW-1:0] exp;
    exp = ref_par(q, id);
    send_frame(1'b0, id, q);
    for (int k = 0; k < CW; k++) begin
      check("R2", "par_vld during emission", par_vld, 1'b1);
      check(req, $sformatf("parity bit %0d", k), par_bit, exp[CW-1-k]);
      if (poke) begin
        frm_start = (k == 5);
        chk_mode  = 1'b1;
      end
      @(negedge clk);
    end
    frm_start = 1'b0;
    check("R2", "par_vld after 24 bits", par_vld, 1'b0);
    check(poke ? "R8" : "R2", "busy after last parity", busy, 1'b0);
  endtask

  task automatic chk_run(input logic [IW-1:0] id_tx, input logic [IW-1:0] id_rx,
                         input bq_t q, input int flip, input bit exp_pass,
                         input string req);
    logic [CW-1:0] p;
    bq_t f;
    p = ref_par(q, id_tx);
    f = q;
    for (int k = 0; k < CW; k++) f.push_back(p[CW-1-k]);
    if (flip >= 0) f[flip] = ~f[flip];
    send_frame(1'b1, id_rx, f);
    check(req, "res_vld", res_vld, 1'b1);
    check(req, "res_pass", res_pass, exp_pass);
    check(req, "res_err", res_err, 1'b0);
    @(negedge clk);
    check("R4", "res_vld one cycle", res_vld, 1'b0);
    check("R4", "busy after result", busy, 1'b0);
  endtask

  task automatic err_run(input bit m, input int n, input string req);
    send_frame(m, 16'h0F0F, mk(n, n));
    check(req, "res_vld on reject", res_vld, 1'b1);
    check(req, "res_err on reject", res_err, 1'b1);
    check(req, "res_pass on reject", res_pass, 1'b0);
    check(req, "no parity on reject", par_vld, 1'b0);
    @(negedge clk);
    check(req, "no parity after reject", par_vld, 1'b0);
    check(req, "idle after reject", busy, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; chk_mode = 1'b0; ident = '0;
    frm_start = 1'b0; frm_end = 1'b0; bit_vld = 1'b0; bit_dat = 1'b0;
    repeat (3) @(negedge clk);
    // R9
    check("R9", "par_vld in reset", par_vld, 1'b0);
    check("R9", "busy in reset", busy, 1'b0);
    check("R9", "res_vld in reset", res_vld, 1'b0);
    check("R9", "res_pass in reset", res_pass, 1'b0);
    check("R9", "res_err in reset", res_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: plain parity, identity zero
    gen_run(16'h0000, mk(1, 3), "R1", 1'b0);
    gen_run(16'h0000, mk(40, 7), "R1", 1'b0);
    // R3: identity merged on trailing bits
    gen_run(16'hA5C3, mk(8, 11), "R3", 1'b0);
    // R7: full-length payload accepted
    gen_run(16'h1234, mk(MAXP, 5), "R7", 1'b0);
    // R8: back-to-back frame, start on the cycle after the last parity bit
    gen_run(16'hFFFF, mk(17, 2), "R8", 1'b0);
    // R8: start while busy ignored
    gen_run(16'h8001, mk(30, 9), "R8", 1'b1);
    @(negedge clk);
    check("R8", "no frame opened by ignored start", busy, 1'b0);

    // R4: matching frames pass
    chk_run(16'h3C5A, 16'h3C5A, mk(40, 4), -1, 1'b1, "R4");
    chk_run(16'h0001, 16'h0001, mk(MAXP, 6), -1, 1'b1, "R4");
    // R5: corruption and wrong identity fail
    chk_run(16'h3C5A, 16'h3C5A, mk(40, 4), 12, 1'b0, "R5");
    chk_run(16'h3C5A, 16'h3C5A, mk(40, 4), 40 + 20, 1'b0, "R5");
    chk_run(16'h3C5A, 16'h3C5B, mk(40, 4), -1, 1'b0, "R5");

    // R6, R7, R10: length rejection
    err_run(1'b0, 0, "R6");
    err_run(1'b0, MAXP + 1, "R7");
    err_run(1'b1, CW, "R10");
    err_run(1'b1, 0, "R10");
    err_run(1'b1, MAXP + CW + 1, "R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule